// File: doc/BRIEF.md
# Clipped Hardware Cursor Overlay

This block places a small hardware cursor over the pixel stream that leaves a display timing generator. Each clock it receives the horizontal and vertical pixel counters, the data-enable flag and the background pixel. Where the counters fall inside the cursor window, it replaces the background with a cursor pixel read from internal storage. Transparent cursor pixels let the background through.

Software first loads an already clipped cursor image through a single register write port. It then sets the screen position, the size and the enable. Position, size and enable are held as pending values. They reach the display together, only at a frame-done strobe, so a frame never shows a half-updated cursor.

Two exceptions take effect at once. An accepted size write blanks the cursor immediately. A zero dimension keeps the cursor dark even after the commit. In interlaced mode the vertical position and height are halved, so one field's rows line up with the window.

Top module: `cursor_overlay`

## Requirements
- R1: A write with `wr_sel`=0 stores `wr_data` at the image write pointer and advances the pointer by one. The pointer fills the 256 words of the first bank (indices 0..255), continues into the second bank (256..511), and wraps back to 0 after 511. A control write with bit 2 set returns the pointer to 0.
- R2: A size write (`wr_sel`=2) carries the value (h<<16)|w. It is rejected, with no effect at all, when w>64, when h>64, or when both w>32 and h>32.
- R3: Position writes (`wr_sel`=1, value (y<<16)|x), accepted size writes and control writes (`wr_sel`=3; bit 0 enable, bit 1 interlace) are held pending. They reach the display only in a cycle with `frame_done` high. A write in that same cycle stays pending and is applied at the following `frame_done`.
- R4: If the committed width or height is zero, the cursor stays hidden whatever the enable bit says.
- R5: An accepted size write hides the cursor from the next cycle on, until the next commit.
- R6: A pixel belongs to the cursor only when `pix_de` is high, x is in [px, px+w) and y is in [py, py+h). It reads image index (y-py)*w + (x-px), taken modulo 512.
- R7: A cursor pixel whose stored alpha byte is zero shows the background. Any non-zero alpha shows the cursor colour.
- R8: An image word 0xAARRGGBB appears on `pix_out` as {BB,GG,RR}, with blue in bits 23:16 and red in bits 7:0. `bg_pix` uses the same layout and passes through unchanged.
- R9: `pix_out` reflects the inputs sampled at the previous rising clock edge. After reset `pix_out` is 0 and the cursor is hidden.
- R10: With the committed interlace bit set, the window uses py>>1 as its top row and h>>1 as its height.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_x | input | CNT_W | Horizontal pixel counter |
| pix_y | input | CNT_W | Vertical pixel counter |
| pix_de | input | 1 | Data enable from the timing generator |
| bg_pix | input | 24 | Background pixel {B,G,R} |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target: 0 image word, 1 position, 2 size, 3 control |
| wr_data | input | 32 | Write data |
| frame_done | input | 1 | End-of-frame strobe that commits pending settings |
| pix_out | output | 24 | Composited pixel {B,G,R} |

## Verification
A register write and the frame-done commit can land in the same clock cycle. The bench provokes this by raising `frame_done` together with a position write while an older position is already pending. The first commit must show the older position and leave the new one dark. The new position must appear only after a second `frame_done`. The same overlap also decides whether a size write's immediate blanking beats a commit that would turn the cursor on; the checker watches that case on every cycle.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

    typedef enum logic [1:0] {
        WS_PIXEL = 2'd0,
        WS_POS   = 2'd1,
        WS_SIZE  = 2'd2,
        WS_CTRL  = 2'd3
    } wsel_e;

    localparam int CTRL_EN_BIT     = 0;
    localparam int CTRL_INTL_BIT   = 1;
    localparam int CTRL_REWIND_BIT = 2;

    // Settings that travel from the pending set to the displayed set.
    typedef struct packed {
        logic [15:0] px;
        logic [15:0] py;
        logic [15:0] w;
        logic [15:0] h;
        logic        en;
        logic        intl;
    } cur_cfg_t;

    // Image words are kept with the red and blue bytes exchanged.
    function automatic logic [31:0] swap_rb(input logic [31:0] d);
        return {d[31:24], d[7:0], d[15:8], d[23:16]};
    endfunction

endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
    import cursor_pkg::*;
#(
    parameter int MAX_LONG  = 64,
    parameter int MAX_SHORT = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic        frame_done,
    output cur_cfg_t    act_cfg,
    output logic        rewind
);

    typedef struct packed {
        cur_cfg_t pend;
        logic     dirty;
        cur_cfg_t act;
    } regs_t;

    regs_t st_d, st_q;

    logic [15:0] new_w, new_h;
    logic        size_ok, sel_pos, sel_size, sel_ctrl;

    always_comb begin
        new_w   = wr_data[15:0];
        new_h   = wr_data[31:16];
        size_ok = (new_w <= 16'(MAX_LONG)) && (new_h <= 16'(MAX_LONG)) &&
                  !((new_w > 16'(MAX_SHORT)) && (new_h > 16'(MAX_SHORT)));
        sel_pos  = wr_en && (wr_sel == WS_POS);
        sel_size = wr_en && (wr_sel == WS_SIZE) && size_ok;
        sel_ctrl = wr_en && (wr_sel == WS_CTRL);

        st_d = st_q;

        // Commit: the displayed set takes the pending set whole.
        if (frame_done && st_q.dirty) begin
            st_d.act    = st_q.pend;
            st_d.act.en = st_q.pend.en && (st_q.pend.w != '0) && (st_q.pend.h != '0);
        end

        // A new size blanks the cursor at once; this wins over a commit.
        if (sel_size) begin
            st_d.act.en = 1'b0;
        end

        if (sel_pos) begin
            st_d.pend.px = wr_data[15:0];
            st_d.pend.py = wr_data[31:16];
        end
        if (sel_size) begin
            st_d.pend.w = new_w;
            st_d.pend.h = new_h;
        end
        if (sel_ctrl) begin
            st_d.pend.en   = wr_data[CTRL_EN_BIT];
            st_d.pend.intl = wr_data[CTRL_INTL_BIT];
        end

        if (sel_pos || sel_size || sel_ctrl) begin
            st_d.dirty = 1'b1;
        end else if (frame_done) begin
            st_d.dirty = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_cfg = st_q.act;
    assign rewind  = sel_ctrl && wr_data[CTRL_REWIND_BIT];

endmodule

// File: rtl/cursor_store.sv
module cursor_store
    import cursor_pkg::*;
#(
    parameter int BANK_WORDS = 256,
    parameter int NBANKS     = 2,
    localparam int BANK_AW   = $clog2(BANK_WORDS),
    localparam int BANK_SW   = $clog2(NBANKS),
    localparam int ADDR_W    = BANK_AW + BANK_SW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_px,
    input  logic [31:0]       wr_word,
    input  logic              rewind,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data
);

    typedef struct packed {
        logic [ADDR_W-1:0]  ptr;
        logic [BANK_SW-1:0] rd_bank;
    } store_t;

    store_t st_d, st_q;

    logic [31:0] bank_rd [NBANKS];

    always_comb begin
        st_d = st_q;
        if (rewind) begin
            st_d.ptr = '0;
        end else if (wr_px) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end
        st_d.rd_bank = rd_addr[ADDR_W-1:BANK_AW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        logic [31:0] mem [BANK_WORDS];
        logic [31:0] rd_q;

        always_ff @(posedge clk) begin
            if (wr_px && (st_q.ptr[ADDR_W-1:BANK_AW] == BANK_SW'(b))) begin
                mem[st_q.ptr[BANK_AW-1:0]] <= swap_rb(wr_word);
            end
            rd_q <= mem[rd_addr[BANK_AW-1:0]];
        end

        assign bank_rd[b] = rd_q;
    end

    assign rd_data = bank_rd[st_q.rd_bank];

endmodule

// File: rtl/cursor_window.sv
module cursor_window
    import cursor_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int ADDR_W = 9
) (
    input  cur_cfg_t          cfg,
    input  logic [CNT_W-1:0]  pix_x,
    input  logic [CNT_W-1:0]  pix_y,
    input  logic              pix_de,
    output logic              hit,
    output logic [ADDR_W-1:0] idx
);

    logic [16:0] xs, ys, left, top, wid, hgt, col, row;
    logic [31:0] lin;
    logic        in_x, in_y;

    always_comb begin
        xs   = 17'(pix_x);
        ys   = 17'(pix_y);
        left = {1'b0, cfg.px};
        wid  = {1'b0, cfg.w};
        top  = cfg.intl ? {2'b00, cfg.py[15:1]} : {1'b0, cfg.py};
        hgt  = cfg.intl ? {2'b00, cfg.h[15:1]}  : {1'b0, cfg.h};

        in_x = (xs >= left) && (xs < (left + wid));
        in_y = (ys >= top)  && (ys < (top + hgt));

        col  = xs - left;
        row  = ys - top;
        lin  = (32'(row) * 32'(wid)) + 32'(col);
        idx  = lin[ADDR_W-1:0];

        hit  = cfg.en && pix_de && in_x && in_y;
    end

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int BANK_WORDS = 256,
    parameter int NBANKS     = 2,
    parameter int MAX_LONG   = 64,
    parameter int MAX_SHORT  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] pix_x,
    input  logic [CNT_W-1:0] pix_y,
    input  logic             pix_de,
    input  logic [23:0]      bg_pix,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [31:0]      wr_data,
    input  logic             frame_done,
    output logic [23:0]      pix_out
);

    localparam int ADDR_W = $clog2(BANK_WORDS) + $clog2(NBANKS);

    typedef struct packed {
        logic        hit;
        logic [23:0] bg;
    } pipe_t;

    pipe_t             pipe_d, pipe_q;
    cur_cfg_t          act_cfg;
    logic              rewind, hit, wr_px;
    logic [ADDR_W-1:0] idx;
    logic [31:0]       rd_word;

    assign wr_px = wr_en && (wr_sel == WS_PIXEL);

    cursor_regs #(
        .MAX_LONG  (MAX_LONG),
        .MAX_SHORT (MAX_SHORT)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .frame_done (frame_done),
        .act_cfg    (act_cfg),
        .rewind     (rewind)
    );

    cursor_window #(
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_window (
        .cfg    (act_cfg),
        .pix_x  (pix_x),
        .pix_y  (pix_y),
        .pix_de (pix_de),
        .hit    (hit),
        .idx    (idx)
    );

    cursor_store #(
        .BANK_WORDS (BANK_WORDS),
        .NBANKS     (NBANKS)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_px   (wr_px),
        .wr_word (wr_data),
        .rewind  (rewind),
        .rd_addr (idx),
        .rd_data (rd_word)
    );

    always_comb begin
        pipe_d     = pipe_q;
        pipe_d.hit = hit;
        pipe_d.bg  = bg_pix;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    always_comb begin
        if (pipe_q.hit && (rd_word[31:24] != 8'h00)) begin
            pix_out = rd_word[23:0];
        end else begin
            pix_out = pipe_q.bg;
        end
    end

endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
    parameter int MAX_LONG  = 64,
    parameter int MAX_SHORT = 32
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [1:0]  wr_sel,
    input logic [31:0] wr_data,
    input logic        frame_done,
    input logic        pix_de,
    input logic [23:0] bg_pix,
    input logic [23:0] pix_out,
    input logic        act_en,
    input logic [15:0] act_px,
    input logic [15:0] act_py,
    input logic [15:0] act_w,
    input logic [15:0] act_h
);

    logic size_wr_ok;
    assign size_wr_ok = wr_en && (wr_sel == 2'd2) &&
                        (wr_data[15:0] <= 16'(MAX_LONG)) && (wr_data[31:16] <= 16'(MAX_LONG)) &&
                        !((wr_data[15:0] > 16'(MAX_SHORT)) && (wr_data[31:16] > 16'(MAX_SHORT)));

    // R2: a shown cursor always has a legal size
    a_r2_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
        act_en |-> ((act_w <= 16'(MAX_LONG)) && (act_h <= 16'(MAX_LONG)) &&
                    !((act_w > 16'(MAX_SHORT)) && (act_h > 16'(MAX_SHORT)))));

    // R3: displayed position moves only on a commit
    a_r3_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> ($stable(act_px) && $stable(act_py)));

    // R4: never shown with an empty dimension
    a_r4_nonzero_dims: assert property (@(posedge clk) disable iff (!rst_n)
        act_en |-> ((act_w != 16'd0) && (act_h != 16'd0)));

    // R5: accepted size write blanks the cursor next cycle
    a_r5_size_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        size_wr_ok |=> !act_en);

    // R6: without data enable the background passes
    a_r6_de_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_de |=> (pix_out == $past(bg_pix)));

endmodule

bind cursor_overlay cursor_overlay_chk #(
    .MAX_LONG  (MAX_LONG),
    .MAX_SHORT (MAX_SHORT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .frame_done (frame_done),
    .pix_de     (pix_de),
    .bg_pix     (bg_pix),
    .pix_out    (pix_out),
    .act_en     (act_cfg.en),
    .act_px     (act_cfg.px),
    .act_py     (act_cfg.py),
    .act_w      (act_cfg.w),
    .act_h      (act_cfg.h)
);

// File: tb/cursor_overlay_bench.sv
module cursor_overlay_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] pix_x, pix_y;
    logic        pix_de;
    logic [23:0] bg_pix;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic        frame_done;
    logic [23:0] pix_out;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    cursor_overlay u_cursor_overlay (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_x      (pix_x),
        .pix_y      (pix_y),
        .pix_de     (pix_de),
        .bg_pix     (bg_pix),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .frame_done (frame_done),
        .pix_out    (pix_out)
    );

    localparam logic [1:0] S_PIX = 2'd0, S_POS = 2'd1, S_SIZE = 2'd2, S_CTRL = 2'd3;

    // {x, y, de, image index or FF for background}; window at (10,5), 4x3
    localparam logic [32:0] VEC [10] = '{
        {12'd10, 12'd5, 1'b1, 8'd0},
        {12'd13, 12'd5, 1'b1, 8'd3},
        {12'd14, 12'd5, 1'b1, 8'hFF},
        {12'd9,  12'd5, 1'b1, 8'hFF},
        {12'd11, 12'd6, 1'b1, 8'd5},
        {12'd12, 12'd7, 1'b1, 8'd10},
        {12'd12, 12'd8, 1'b1, 8'hFF},
        {12'd12, 12'd4, 1'b1, 8'hFF},
        {12'd10, 12'd5, 1'b0, 8'hFF},
        {12'd13, 12'd7, 1'b1, 8'd11}
    };

    function automatic logic [31:0] img_a(input int i);
        return {(i == 5) ? 8'h00 : 8'hFF, 8'(i), 8'(8'h40 + i), 8'(8'h80 + i)};
    endfunction
    function automatic logic [23:0] exp_a(input int i);
        return {8'(8'h80 + i), 8'(8'h40 + i), 8'(i)};
    endfunction
    function automatic logic [31:0] img_b(input int k);
        return {8'hFF, 8'(k), 7'd0, 1'(k >> 8), 8'h33};
    endfunction
    function automatic logic [23:0] exp_b(input int k);
        return {8'h33, 7'd0, 1'(k >> 8), 8'(k)};
    endfunction
    function automatic logic [23:0] bgf(input int x, input int y);
        return {8'hC0, 8'(x), 8'(y)};
    endfunction

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fdone();
        @(negedge clk);
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
    endtask

    task automatic probe(input int x, input int y, input logic de, output logic [23:0] got);
        @(negedge clk);
        pix_x = 12'(x); pix_y = 12'(y); pix_de = de; bg_pix = bgf(x, y);
        @(posedge clk);
        #2;
        got = pix_out;
    endtask

    task automatic see(input string req, input int x, input int y, input logic [23:0] exp);
        logic [23:0] got;
        probe(x, y, 1'b1, got);
        chk(req, got, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [23:0] got, exp;
        rst_n = 1'b0; pix_x = '0; pix_y = '0; pix_de = 1'b0; bg_pix = '0;
        wr_en = 1'b0; wr_sel = '0; wr_data = '0; frame_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R9 reset output", pix_out, 24'h0);
        see("R9 hidden after reset", 10, 5, bgf(10, 5));

        // image A, 4x3 at (10,5)
        wr(S_CTRL, 32'h4);
        for (int i = 0; i < 12; i++) wr(S_PIX, img_a(i));
        wr(S_POS, {16'd5, 16'd10});
        wr(S_SIZE, {16'd3, 16'd4});
        wr(S_CTRL, 32'h1);
        fdone();

        // R6 R7 R8: table walk
        for (int k = 0; k < 10; k++) begin
            int x, y, idx;
            logic de;
            x = int'(VEC[k][32:21]); y = int'(VEC[k][20:9]);
            de = VEC[k][8]; idx = int'(VEC[k][7:0]);
            probe(x, y, de, got);
            if (idx == 255 || img_a(idx)[31:24] == 8'h00) exp = bgf(x, y);
            else exp = exp_a(idx);
            chk($sformatf("R6 R7 R8 vector %0d", k), got, exp);
        end

        // R3: pending position waits for frame_done
        wr(S_POS, {16'd5, 16'd20});
        see("R3 old position kept", 10, 5, exp_a(0));
        see("R3 new position not yet", 20, 5, bgf(20, 5));
        fdone();
        see("R3 new position after commit", 20, 5, exp_a(0));
        see("R3 old position gone", 10, 5, bgf(10, 5));

        // R3: write in the same cycle as frame_done
        wr(S_POS, {16'd5, 16'd40});
        @(negedge clk);
        wr_en = 1'b1; wr_sel = S_POS; wr_data = {16'd5, 16'd50}; frame_done = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; frame_done = 1'b0;
        see("R3 overlap commits older value", 40, 5, exp_a(0));
        see("R3 overlap write still pending", 50, 5, bgf(50, 5));
        fdone();
        see("R3 overlap write after next commit", 50, 5, exp_a(0));

        // R5: size write blanks at once
        wr(S_SIZE, {16'd3, 16'd4});
        see("R5 size write blanks", 50, 5, bgf(50, 5));
        fdone();
        see("R5 back after commit", 50, 5, exp_a(0));

        // R2: illegal sizes ignored
        wr(S_SIZE, {16'd40, 16'd40});
        see("R2 illegal size no blanking", 50, 5, exp_a(0));
        wr(S_SIZE, {16'd1, 16'd65});
        fdone();
        see("R2 width unchanged", 54, 5, bgf(54, 5));
        see("R2 size unchanged", 53, 7, exp_a(11));

        // R4: zero dimensions
        wr(S_SIZE, {16'd3, 16'd0});
        fdone();
        see("R4 zero width hidden", 50, 5, bgf(50, 5));
        wr(S_SIZE, {16'd0, 16'd4});
        fdone();
        see("R4 zero height hidden", 50, 5, bgf(50, 5));
        wr(S_SIZE, {16'd3, 16'd4});
        fdone();
        see("R4 restored", 50, 5, exp_a(0));

        // R10: interlace halves top and height
        wr(S_POS, {16'd10, 16'd50});
        wr(S_SIZE, {16'd6, 16'd4});
        wr(S_CTRL, 32'h3);
        fdone();
        see("R10 top row halved", 50, 5, exp_a(0));
        see("R10 last row", 53, 7, exp_a(11));
        see("R10 height halved", 50, 8, bgf(50, 8));
        see("R10 unhalved top unused", 50, 10, bgf(50, 10));

        // R1: bank rollover and wrap
        wr(S_CTRL, 32'h5);
        for (int k = 0; k < 300; k++) wr(S_PIX, img_b(k));
        wr(S_POS, {16'd0, 16'd100});
        wr(S_SIZE, {16'd5, 16'd64});
        fdone();
        see("R1 second bank word", 102, 4, exp_b(258));
        see("R1 first bank intact", 102, 0, exp_b(2));
        see("R1 last word of first bank", 163, 3, exp_b(255));
        for (int k = 300; k < 512; k++) wr(S_PIX, img_b(k));
        wr(S_PIX, 32'hFF123456);
        see("R1 R8 pointer wrap", 100, 0, 24'h563412);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule